// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block turns interrupt line activity into delivery messages. Each pin has a 64-bit redirection entry. The entries come in on a flat input bus, and a register block elsewhere owns them. An entry sets the pin's polarity, trigger style, mask, vector, delivery mode and destination. Line activity arrives as single-cycle events, each carrying a line number and a level. The block keeps a pending bit per pin. It always picks the lowest-numbered pin that is eligible and sends one message for it over a valid/ready handshake.

Level-triggered pins have an in-service flag that the engine keeps itself and exports on `rirr_o`, so the owner of the table can show it. A level pin with the flag set is not delivered again. An end-of-interrupt broadcast clears the flag on every pin whose vector matches, and a pin that is still pending is then delivered again. A pin whose delivery mode is external takes its vector from a legacy controller through a request/acknowledge side port before its message is offered.

Top module: `redir_deliver`

## Requirements
- R1: Entry layout per pin (entry i at bits 64*i+63 : 64*i): vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15 (1 = level, 0 = edge), mask 16 (1 = masked), destination 63:56. Bits 12, 14 and 17 to 55 are ignored. A message carries these fields and the trigger bit from the entry of the pin it serves.
- R2: When polarity is 1, the event level is inverted before any further use.
- R3: On a level pin, an event sets the pending bit when the effective level is 1 and clears it when the level is 0, whatever the mask. A masked level pin that is pending is delivered once it is unmasked.
- R4: On an edge pin, an effective level of 1 sets the pending bit only when the pin is unmasked. An event on a masked edge pin is dropped, and unmasking the pin later delivers nothing.
- R5: A pin is eligible when it is pending, unmasked, and not a level pin whose in-service flag is set. When several pins are eligible, the lowest-numbered pin goes first.
- R6: Accepting an edge pin's message clears its pending bit, so each edge event produces exactly one message.
- R7: Accepting a level pin's message sets that pin's bit in `rirr_o`. No further message comes from that pin while the bit is set.
- R8: An EOI with vector V clears `rirr_o` for every pin whose entry vector equals V. A pin that is still pending is then delivered again. An EOI with a vector that no in-service pin uses has no effect.
- R9: Delivery mode 7 raises `pic_req` until `pic_ack`. The message then carries `pic_vector` instead of the entry vector. Other modes never raise `pic_req`, and `pic_req` and `msg_valid` are never high together.
- R10: Line 0 drives pin 2. Any other line n drives pin n. Lines with no pin (n >= NPINS) are ignored.
- R11: At most one message is outstanding. While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and every message field holds its value.
- R12: After reset, no pin is pending, `rirr_o` is 0, and `msg_valid` and `pic_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Line event strobe |
| evt_line | input | LINE_W | Line number of the event |
| evt_level | input | 1 | Raw line level of the event |
| redir_tbl | input | NPINS*64 | Redirection entries, pin i at bits 64*i+63:64*i |
| rirr_o | output | NPINS | Per-pin in-service flags of level pins |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector of the broadcast |
| pic_req | output | 1 | Vector request to the legacy controller |
| pic_ack | input | 1 | Legacy controller answers |
| pic_vector | input | 8 | Vector from the legacy controller |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Delivery message accepted |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_trig | output | 1 | Trigger style, 1 = level |

## Verification
The bench targets the places where edge and level pins part ways.

- A level pin whose in-service flag is not honoured floods the output with repeated messages.
- A design that keeps masked edge events would deliver a stale interrupt as soon as the pin is unmasked.
- An EOI that ignores the vector compare would clear the flag on the wrong pins.

It also checks ordering, the line-0 remap and the ExtINT fetch.

- Two pins unmasked in the same cycle must come out lowest first.
- A wrong remap would fire pin 0 instead of pin 2.
- An ExtINT message built from the entry vector would show the table's vector instead of the one the legacy controller answered.

A long random phase mixes events, EOIs and back-pressure against a model of the pending and in-service bits.

// File: rtl/redir_deliver.sv
module redir_deliver #(
  parameter int NPINS  = 24,
  parameter int LINE_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_valid,
  input  logic [LINE_W-1:0]     evt_line,
  input  logic                  evt_level,
  input  logic [NPINS*64-1:0]   redir_tbl,
  output logic [NPINS-1:0]      rirr_o,
  input  logic                  eoi_valid,
  input  logic [7:0]            eoi_vector,
  output logic                  pic_req,
  input  logic                  pic_ack,
  input  logic [7:0]            pic_vector,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [7:0]            msg_dest,
  output logic                  msg_dest_mode,
  output logic [2:0]            msg_deliv_mode,
  output logic [7:0]            msg_vector,
  output logic                  msg_trig
);

  localparam int ENTRY_W = 64;
  localparam int PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int F_DM    = 8;
  localparam int F_DMODE = 11;
  localparam int F_POL   = 13;
  localparam int F_TRIG  = 15;
  localparam int F_MASK  = 16;
  localparam int F_DEST  = 56;
  localparam logic [2:0] DM_EXT = 3'd7;

  typedef enum logic [1:0] {ST_SCAN, ST_FETCH, ST_SEND} st_t;

  st_t                state;
  logic [NPINS-1:0]   irr_q, rirr_q;
  logic [NPINS-1:0]   mask_v, trig_v, pol_v, dmode_v;
  logic [7:0]         vec_v  [NPINS];
  logic [7:0]         dest_v [NPINS];
  logic [2:0]         dm_v   [NPINS];
  logic [NPINS-1:0]   evt_hit, eoi_hit, eff_v, dlv, unused_bits;
  logic [NPINS-1:0]   set_v, clr_lvl, dlv_edge, dlv_lvl, elig;
  logic [LINE_W-1:0]  mapped;
  logic [PIN_W-1:0]   sel_idx, cap_idx;
  logic               sel_found, accept;

  assign mapped = (evt_line == '0) ? LINE_W'(2) : evt_line;
  assign accept = msg_valid && msg_ready;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int B = i * ENTRY_W;
    assign vec_v[i]   = redir_tbl[B +: 8];
    assign dm_v[i]    = redir_tbl[B+F_DM +: 3];
    assign dmode_v[i] = redir_tbl[B+F_DMODE];
    assign pol_v[i]   = redir_tbl[B+F_POL];
    assign trig_v[i]  = redir_tbl[B+F_TRIG];
    assign mask_v[i]  = redir_tbl[B+F_MASK];
    assign dest_v[i]  = redir_tbl[B+F_DEST +: 8];
    assign unused_bits[i] = ^{redir_tbl[B+12], redir_tbl[B+14], redir_tbl[B+F_DEST-1:B+F_MASK+1]};
    assign evt_hit[i] = evt_valid && (int'(mapped) == i);
    assign eoi_hit[i] = eoi_valid && rirr_q[i] && (vec_v[i] == eoi_vector);
    assign dlv[i]     = accept && (cap_idx == PIN_W'(i));
  end

  assign eff_v    = {NPINS{evt_level}} ^ pol_v;
  assign set_v    = evt_hit & eff_v & (trig_v | ~mask_v);
  assign clr_lvl  = evt_hit & trig_v & ~eff_v;
  assign dlv_edge = dlv & ~{NPINS{msg_trig}};
  assign dlv_lvl  = dlv & {NPINS{msg_trig}};
  assign elig     = irr_q & ~mask_v & ~(trig_v & rirr_q);

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel_found = 1'b1;
        sel_idx   = PIN_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      rirr_q <= '0;
    end else begin
      irr_q  <= (irr_q & ~clr_lvl & ~dlv_edge) | set_v;
      rirr_q <= (rirr_q & ~eoi_hit) | dlv_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_SCAN;
      cap_idx        <= '0;
      msg_dest       <= '0;
      msg_dest_mode  <= 1'b0;
      msg_deliv_mode <= '0;
      msg_vector     <= '0;
      msg_trig       <= 1'b0;
    end else begin
      case (state)
        ST_SCAN: if (sel_found) begin
          cap_idx        <= sel_idx;
          msg_dest       <= dest_v[sel_idx];
          msg_dest_mode  <= dmode_v[sel_idx];
          msg_deliv_mode <= dm_v[sel_idx];
          msg_vector     <= vec_v[sel_idx];
          msg_trig       <= trig_v[sel_idx];
          state          <= (dm_v[sel_idx] == DM_EXT) ? ST_FETCH : ST_SEND;
        end
        ST_FETCH: if (pic_ack) begin
          msg_vector <= pic_vector;
          state      <= ST_SEND;
        end
        ST_SEND: if (msg_ready) state <= ST_SCAN;
        default: state <= ST_SCAN;
      endcase
    end
  end

  assign msg_valid = (state == ST_SEND);
  assign pic_req   = (state == ST_FETCH);
  assign rirr_o    = rirr_q;

endmodule

// File: rtl/redir_deliver_chk.sv
module redir_deliver_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_dest,
  input logic             msg_dest_mode,
  input logic [2:0]       msg_deliv_mode,
  input logic [7:0]       msg_vector,
  input logic             msg_trig,
  input logic             pic_req,
  input logic             pic_ack,
  input logic             eoi_valid,
  input logic [NPINS-1:0] rirr_o
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_dest_mode)
      && $stable(msg_deliv_mode) && $stable(msg_vector) && $stable(msg_trig)));

  p_pic_solo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pic_req && msg_valid));

  p_pic_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pic_req && !pic_ack) |=> pic_req);

  p_ext_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && msg_deliv_mode == 3'd7) |-> $past(pic_req && pic_ack));

  p_own_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && msg_deliv_mode != 3'd7) |-> !$past(pic_req));

  p_rirr_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rirr_o & ~$past(rirr_o))) |-> $past(msg_valid && msg_ready && msg_trig));

  p_rirr_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(rirr_o) & ~rirr_o)) |-> $past(eoi_valid));

  p_reset_r12: assert property (@(posedge clk)
    !rst_n |=> (!msg_valid && !pic_req && rirr_o == '0));

endmodule

bind redir_deliver redir_deliver_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_deliv_mode(msg_deliv_mode),
  .msg_vector(msg_vector), .msg_trig(msg_trig), .pic_req(pic_req), .pic_ack(pic_ack),
  .eoi_valid(eoi_valid), .rirr_o(rirr_o)
);

// File: tb/tb_redir_deliver.sv
module tb_redir_deliver;
  localparam int NP = 24;
  localparam int LW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_level = 1'b0;
  logic [LW-1:0] evt_line = '0;
  logic [NP*64-1:0] redir_tbl = '0;
  logic [NP-1:0] rirr_o;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic pic_req, pic_ack = 1'b0;
  logic [7:0] pic_vector = '0;
  logic msg_valid, msg_ready = 1'b0;
  logic [7:0] msg_dest, msg_vector;
  logic msg_dest_mode, msg_trig;
  logic [2:0] msg_deliv_mode;

  redir_deliver #(.NPINS(NP), .LINE_W(LW)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] tbl [NP];
  bit m_irr [NP];
  bit m_rirr [NP];
  logic [7:0] pic_cnt = 8'h30, pic_exp = 8'h30;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [7:0] vec, logic [2:0] dm, bit dmode, bit pol,
                                     bit trig, bit mask, logic [7:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmode; e[13] = pol;
    e[15] = trig; e[16] = mask; e[63:56] = dest;
    return e;
  endfunction

  task automatic set_entry(int p, logic [63:0] v);
    @(negedge clk);
    tbl[p] = v;
    redir_tbl[p*64 +: 64] = v;
  endtask

  task automatic set_pair(int p, logic [63:0] v, int q, logic [63:0] w);
    @(negedge clk);
    tbl[p] = v; redir_tbl[p*64 +: 64] = v;
    tbl[q] = w; redir_tbl[q*64 +: 64] = w;
  endtask

  task automatic ev(int line, bit lvl);
    int p;
    bit eff;
    @(negedge clk);
    evt_valid = 1'b1; evt_line = LW'(line); evt_level = lvl;
    p = (line == 0) ? 2 : line;
    if (p < NP) begin
      eff = lvl ^ tbl[p][13];
      if (tbl[p][15]) m_irr[p] = eff;
      else if (eff && !tbl[p][16]) m_irr[p] = 1'b1;
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic eoi(logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    for (int p = 0; p < NP; p++)
      if (m_rirr[p] && tbl[p][7:0] == v) m_rirr[p] = 1'b0;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int p = 0; p < NP; p++) begin m_irr[p] = 0; m_rirr[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(string req, bit rnd_ready);
    logic [20:0] exp_m [NP];
    logic [20:0] act_m;
    logic [NP-1:0] exp_r;
    int n = 0;
    bit extra = 0, got;
    for (int p = 0; p < NP; p++) begin
      if (m_irr[p] && !tbl[p][16] && !(tbl[p][15] && m_rirr[p])) begin
        logic [7:0] v;
        if (tbl[p][10:8] == 3'd7) begin v = pic_exp; pic_exp = pic_exp + 8'd1; end
        else v = tbl[p][7:0];
        exp_m[n] = {tbl[p][63:56], tbl[p][11], tbl[p][10:8], v, tbl[p][15]};
        n++;
        if (tbl[p][15]) m_rirr[p] = 1'b1; else m_irr[p] = 1'b0;
      end
    end
    for (int k = 0; k < n; k++) begin
      got = 0;
      for (int c = 0; c < 400 && !got; c++) begin
        @(negedge clk);
        msg_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
        #1;
        if (msg_valid && msg_ready) got = 1;
      end
      act_m = {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_trig};
      check(got && act_m == exp_m[k], req, {43'd0, act_m}, {43'd0, exp_m[k]});
    end
    @(negedge clk);
    msg_ready = 1'b1;
    repeat (14) begin
      @(negedge clk);
      if (msg_valid || pic_req) extra = 1;
    end
    check(!extra, {req, " no extra message (R6 R7)"}, 64'(extra), 64'd0);
    for (int p = 0; p < NP; p++) exp_r[p] = m_rirr[p];
    check(rirr_o == exp_r, {req, " in-service flags (R7 R8)"}, 64'(rirr_o), 64'(exp_r));
    msg_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (pic_ack) pic_ack = 1'b0;
      else if (pic_req && (($urandom % 3) == 0)) begin
        pic_ack = 1'b1;
        pic_vector = pic_cnt;
        pic_cnt = pic_cnt + 8'd1;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [20:0] held;
    bit stable;
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) begin tbl[p] = mk(8'h00, 3'd0, 0, 0, 0, 1, 8'h00); redir_tbl[p*64 +: 64] = tbl[p]; end
    do_reset();
    @(negedge clk);
    check(!msg_valid && !pic_req && rirr_o == '0, "R12 reset state",
          {62'd0, msg_valid, pic_req}, 64'd0);

    // R1 R6: field transport on an edge pin
    set_entry(5, mk(8'h41, 3'd1, 1, 0, 0, 0, 8'h9C));
    ev(5, 1);
    drain("R1 R6 edge fields", 0);

    // R2: inverted polarity
    set_entry(3, mk(8'h23, 3'd0, 0, 1, 0, 0, 8'h11));
    ev(3, 1);
    drain("R2 inverted high ignored", 0);
    ev(3, 0);
    drain("R2 inverted low delivers", 0);

    // R4: masked edge events dropped
    set_entry(4, mk(8'h44, 3'd4, 0, 0, 0, 1, 8'h22));
    ev(4, 1);
    drain("R4 masked edge", 0);
    set_entry(4, mk(8'h44, 3'd4, 0, 0, 0, 0, 8'h22));
    drain("R4 unmask no stale", 0);
    ev(4, 1);
    drain("R4 unmasked edge", 0);

    // R7 R8 R11: level pin with in-service flag and back-pressure
    set_entry(6, mk(8'h66, 3'd0, 1, 0, 1, 0, 8'h33));
    msg_ready = 1'b0;
    ev(6, 1);
    stable = 1;
    for (int c = 0; c < 20 && !msg_valid; c++) @(negedge clk);
    held = {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_trig};
    repeat (5) begin
      @(negedge clk);
      if (!msg_valid || held != {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector, msg_trig}) stable = 0;
    end
    check(stable, "R11 held under back-pressure", {43'd0, held}, {43'd0, held});
    drain("R7 level first delivery", 0);
    eoi(8'h67);
    drain("R8 non-matching EOI", 0);
    eoi(8'h66);
    drain("R8 EOI redelivers held level", 0);
    ev(6, 0);
    eoi(8'h66);
    drain("R3 level cleared then EOI", 0);
    ev(6, 1);
    drain("R3 level reassert", 1);

    // R3: masked level pin delivers on unmask
    set_entry(7, mk(8'h77, 3'd2, 0, 0, 1, 1, 8'h44));
    ev(7, 1);
    drain("R3 masked level held", 0);
    set_entry(7, mk(8'h77, 3'd2, 0, 0, 1, 0, 8'h44));
    drain("R3 unmask delivers", 0);

    // R5: two pins made eligible in the same cycle
    set_pair(10, mk(8'hA0, 3'd0, 0, 0, 1, 1, 8'h0A), 12, mk(8'hC0, 3'd0, 0, 0, 1, 1, 8'h0C));
    ev(12, 1);
    ev(10, 1);
    set_pair(10, mk(8'hA0, 3'd0, 0, 0, 1, 0, 8'h0A), 12, mk(8'hC0, 3'd0, 0, 0, 1, 0, 8'h0C));
    drain("R5 lowest pin first", 1);

    // R9: external vector fetch
    set_entry(11, mk(8'hBB, 3'd7, 0, 0, 0, 0, 8'h55));
    ev(11, 1);
    drain("R9 external vector", 1);

    // R10: line routing
    set_entry(0, mk(8'h01, 3'd0, 0, 0, 0, 0, 8'h66));
    set_entry(2, mk(8'h02, 3'd0, 0, 0, 0, 0, 8'h77));
    ev(0, 1);
    drain("R10 line 0 to pin 2", 0);
    ev(31, 1);
    ev(25, 1);
    drain("R10 out-of-range lines", 0);

    // random phase
    do_reset();
    for (int p = 0; p < NP; p++) begin
      int r = $urandom % 7;
      tbl[p] = mk(8'h50 + 8'($urandom % 4), 3'(r < 3 ? r : r + 1), bit'($urandom % 2),
                  bit'($urandom % 2), bit'($urandom % 2), ($urandom % 4) == 0, 8'($urandom));
      redir_tbl[p*64 +: 64] = tbl[p];
    end
    for (int op = 0; op < 150; op++) begin
      if (($urandom % 10) < 7) ev(int'($urandom % 28), bit'($urandom % 2));
      else eoi(8'h50 + 8'($urandom % 4));
      drain("R5 random mix", 1);
    end
    finish_run();
  end
endmodule